// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block sits between an interrupt distributor and one processor. Each cycle the distributor offers its best pending candidate: an interrupt number, the number of the CPU that raised it (meaningful only for software interrupts), and an 8-bit priority where a smaller value is more urgent. The block compares that candidate against a software-written priority threshold, a signalling enable, and the priority of the interrupt currently being serviced. From this it drives the processor's interrupt request line.

Software talks to the block through a small register port. Reading the acknowledge register returns the interrupt number in bits 9:0 and the source CPU in bits 12:10. It also marks the interrupt as in service and sends a one-cycle notice to the distributor, which then clears the pending state of edge sources. When nothing can be taken, the read returns the reserved number 1023. Writing the acknowledged value back to the completion register ends service and notifies the distributor. Only one interrupt can be in service at a time. A more urgent candidate that arrives during service raises the request line, but it is handed out only after the current one completes.

Top module: `ciack_top`

## Requirements
- R1: After reset, signalling is off, the threshold is 0, nothing is in service, the request line is low and the completion and take notices are low.
- R2: Bit 0 of the control register (address 0) enables signalling. While it is 0, the request line stays low and acknowledge returns 1023.
- R3: A candidate is eligible only when its priority value is strictly below the 8-bit threshold register (address 1, bits 7:0). A priority equal to the threshold is blocked.
- R4: An acknowledge read (address 2) of an eligible candidate returns the number in bits 9:0. Bits 12:10 hold the source CPU when the number is below 16 and are zero otherwise. All bits above 12 are zero.
- R5: When nothing can be taken, an acknowledge read returns 1023, raises no take notice and leaves the in-service state unchanged.
- R6: A successful acknowledge pulses take_o for one cycle with the number on take_id_o, and the interrupt becomes in service. A candidate of equal or lower urgency then no longer drives the request line.
- R7: While an interrupt is in service, the request line is driven only by a candidate whose priority value is strictly below the in-service priority. An acknowledge read returns 1023 until completion.
- R8: A write to the completion register (address 3) whose bits 12:0 equal the in-service acknowledge value ends service and pulses done_o for one cycle with the number on done_id_o. A write of any other value, or a write when nothing is in service, is ignored.
- R9: Candidate numbers 1020 to 1023 are never eligible.
- R10: Read data appears on bus_rdata_o in the cycle after the read strobe and holds until the next read. Reads of address 0 return the enable in bit 0, reads of address 1 return the threshold, and reads of address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cand_vld_i | input | 1 | Distributor offers a candidate |
| cand_id_i | input | 10 | Candidate interrupt number |
| cand_src_i | input | 3 | Requesting CPU for software interrupts |
| cand_prio_i | input | 8 | Candidate priority, lower is more urgent |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register select: 0 control, 1 threshold, 2 acknowledge, 3 completion |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, valid the cycle after the read |
| irq_o | output | 1 | Interrupt request to the processor |
| take_o | output | 1 | One-cycle notice that a candidate was acknowledged |
| take_id_o | output | 10 | Number acknowledged |
| done_o | output | 1 | One-cycle notice that service completed |
| done_id_o | output | 10 | Number completed |

## Verification
The hardest state to reach is a mismatched completion while an interrupt is in service, because it leaves no trace on any output. The bench first acknowledges a software interrupt so the source bits are non-zero. It then writes back the same number with different source bits and shows that done_o stays low and that a following acknowledge still returns 1023. Preemption signalling also needs a deliberate sequence: put one interrupt in service, then offer a strictly more urgent candidate, an equally urgent one and a less urgent one, and observe the request line for each. Random rounds then mix candidates, threshold changes and right and wrong completions, and compare against a model in the bench.

// File: rtl/ciack_pkg.sv
package ciack_pkg;
    localparam int ID_W    = 10;
    localparam int SRC_W   = 3;
    localparam int PRIO_W  = 8;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 2;
    localparam int SWI_CNT = 16;
    localparam int VAL_W   = ID_W + SRC_W;
    localparam logic [ID_W-1:0] SPUR_ID  = {ID_W{1'b1}};
    localparam logic [ID_W-1:0] RSVD_LO  = SPUR_ID - 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_MASK = 2'd1;
    localparam logic [ADDR_W-1:0] A_ACK  = 2'd2;
    localparam logic [ADDR_W-1:0] A_EOI  = 2'd3;

    typedef struct packed {
        logic              en;
        logic [PRIO_W-1:0] pmask;
        logic              act;
        logic [VAL_W-1:0]  act_val;
        logic [PRIO_W-1:0] act_prio;
        logic [DATA_W-1:0] rdata;
        logic              take;
        logic [ID_W-1:0]   take_id;
        logic              done;
        logic [ID_W-1:0]   done_id;
    } ciack_state_t;
endpackage

// File: rtl/ciack_elig.sv
module ciack_elig
    import ciack_pkg::*;
(
    input  logic              en_i,
    input  logic [PRIO_W-1:0] pmask_i,
    input  logic              act_i,
    input  logic [PRIO_W-1:0] act_prio_i,
    input  logic              cand_vld_i,
    input  logic [ID_W-1:0]   cand_id_i,
    input  logic [PRIO_W-1:0] cand_prio_i,
    output logic              signal_o,
    output logic              grant_o
);
    logic base_ok;

    always_comb begin
        base_ok  = en_i && cand_vld_i && (cand_id_i < RSVD_LO) && (cand_prio_i < pmask_i);
        signal_o = base_ok && (!act_i || (cand_prio_i < act_prio_i));
        grant_o  = base_ok && !act_i;
    end
endmodule

// File: rtl/ciack_encode.sv
module ciack_encode
    import ciack_pkg::*;
(
    input  logic             grant_i,
    input  logic [ID_W-1:0]  cand_id_i,
    input  logic [SRC_W-1:0] cand_src_i,
    output logic [VAL_W-1:0] val_o
);
    always_comb begin
        if (!grant_i) begin
            val_o = {{SRC_W{1'b0}}, SPUR_ID};
        end else if (cand_id_i < ID_W'(SWI_CNT)) begin
            val_o = {cand_src_i, cand_id_i};
        end else begin
            val_o = {{SRC_W{1'b0}}, cand_id_i};
        end
    end
endmodule

// File: rtl/ciack_top.sv
module ciack_top
    import ciack_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cand_vld_i,
    input  logic [ID_W-1:0]   cand_id_i,
    input  logic [SRC_W-1:0]  cand_src_i,
    input  logic [PRIO_W-1:0] cand_prio_i,
    input  logic              bus_rd_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              irq_o,
    output logic              take_o,
    output logic [ID_W-1:0]   take_id_o,
    output logic              done_o,
    output logic [ID_W-1:0]   done_id_o
);
    ciack_state_t st_d, st_q;
    logic             signal_w, grant_w;
    logic [VAL_W-1:0] ack_val_w;

    ciack_elig u_elig (
        .en_i       (st_q.en),
        .pmask_i    (st_q.pmask),
        .act_i      (st_q.act),
        .act_prio_i (st_q.act_prio),
        .cand_vld_i (cand_vld_i),
        .cand_id_i  (cand_id_i),
        .cand_prio_i(cand_prio_i),
        .signal_o   (signal_w),
        .grant_o    (grant_w)
    );

    ciack_encode u_enc (
        .grant_i   (grant_w),
        .cand_id_i (cand_id_i),
        .cand_src_i(cand_src_i),
        .val_o     (ack_val_w)
    );

    always_comb begin
        st_d      = st_q;
        st_d.take = 1'b0;
        st_d.done = 1'b0;
        if (bus_wr_i) begin
            case (bus_addr_i)
                A_CTRL: st_d.en = bus_wdata_i[0];
                A_MASK: st_d.pmask = bus_wdata_i[PRIO_W-1:0];
                A_EOI: begin
                    if (st_q.act && (bus_wdata_i[VAL_W-1:0] == st_q.act_val)) begin
                        st_d.act     = 1'b0;
                        st_d.done    = 1'b1;
                        st_d.done_id = st_q.act_val[ID_W-1:0];
                    end
                end
                default: ;
            endcase
        end
        if (bus_rd_i) begin
            case (bus_addr_i)
                A_CTRL: st_d.rdata = {{(DATA_W-1){1'b0}}, st_q.en};
                A_MASK: st_d.rdata = {{(DATA_W-PRIO_W){1'b0}}, st_q.pmask};
                A_ACK: begin
                    st_d.rdata = {{(DATA_W-VAL_W){1'b0}}, ack_val_w};
                    if (grant_w) begin
                        st_d.act      = 1'b1;
                        st_d.act_val  = ack_val_w;
                        st_d.act_prio = cand_prio_i;
                        st_d.take     = 1'b1;
                        st_d.take_id  = cand_id_i;
                    end
                end
                default: st_d.rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata_o = st_q.rdata;
    assign irq_o       = signal_w;
    assign take_o      = st_q.take;
    assign take_id_o   = st_q.take_id;
    assign done_o      = st_q.done;
    assign done_id_o   = st_q.done_id;

    // R5: a read with nothing to take gives the spurious number and no notice
    p_spurious_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i == A_ACK && !grant_w && !bus_wr_i)
        |=> (!take_o && bus_rdata_o[ID_W-1:0] == SPUR_ID));

    // R6: a take notice follows an eligible acknowledge and leaves it in service
    p_take_follows_ack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd_i && bus_addr_i == A_ACK && grant_w) |=> (take_o && st_q.act));

    // R7: no second take while the first is still in service
    p_no_double_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !take_o);

    // R8: a completion notice requires an interrupt that was in service
    p_done_had_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(st_q.act) && !st_q.act));

    // R2: request line silent while signalling is disabled
    p_irq_off_when_disabled_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.en) |-> !irq_o);
endmodule

// File: tb/sim_ciack_top.sv
module sim_ciack_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cand_vld = 1'b0;
    logic [9:0]  cand_id = '0;
    logic [2:0]  cand_src = '0;
    logic [7:0]  cand_prio = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq, take, done;
    logic [9:0]  take_id, done_id;

    int n_chk = 0;
    int n_err = 0;

    // bench model
    bit        m_en = 0;
    bit [7:0]  m_mask = 0;
    bit        m_act = 0;
    bit [12:0] m_val = 0;
    bit [7:0]  m_prio = 0;

    always #5 clk = ~clk;

    ciack_top u0 (
        .clk(clk), .rst_n(rst_n),
        .cand_vld_i(cand_vld), .cand_id_i(cand_id), .cand_src_i(cand_src),
        .cand_prio_i(cand_prio),
        .bus_rd_i(bus_rd), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
        .irq_o(irq), .take_o(take), .take_id_o(take_id),
        .done_o(done), .done_id_o(done_id)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit base_ok();
        return m_en && cand_vld && (cand_id < 10'd1020) && (cand_prio < m_mask);
    endfunction

    function automatic bit exp_irq();
        return base_ok() && (!m_act || cand_prio < m_prio);
    endfunction

    function automatic bit [12:0] exp_ack();
        if (!(base_ok() && !m_act)) return 13'd1023;
        if (cand_id < 10'd16) return {cand_src, cand_id};
        return {3'b000, cand_id};
    endfunction

    task automatic set_cand(input bit v, input int id, input int src, input int pr);
        @(negedge clk);
        cand_vld = v; cand_id = 10'(id); cand_src = 3'(src); cand_prio = 8'(pr);
        #1;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [31:0] d, input string req);
        bit hit;
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        hit = (a == 2'd3) && m_act && (d[12:0] == m_val);
        @(negedge clk);
        bus_wr = 1'b0;
        if (a == 2'd0) m_en = d[0];
        if (a == 2'd1) m_mask = d[7:0];
        if (a == 2'd3) begin
            check(req, {31'b0, done}, {31'b0, hit});
            if (hit) begin
                check(req, {22'b0, done_id}, {22'b0, m_val[9:0]});
                m_act = 0;
            end
        end
    endtask

    task automatic ack_read(input string req, output bit [12:0] got);
        bit [12:0] e;
        bit        g;
        @(negedge clk);
        e = exp_ack();
        g = (e != 13'd1023);
        bus_rd = 1'b1; bus_addr = 2'd2;
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, bus_rdata, {19'b0, e});
        check(req, {31'b0, take}, {31'b0, g});
        if (g) begin
            check(req, {22'b0, take_id}, {22'b0, e[9:0]});
            m_act = 1; m_val = e; m_prio = cand_prio;
        end
        got = e;
    endtask

    task automatic reg_read(input logic [1:0] a, input logic [31:0] e, input string req);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        check(req, bus_rdata, e);
    endtask

    task automatic chk_irq(input string req);
        check(req, {31'b0, irq}, {31'b0, exp_irq()});
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        bit [12:0] v;
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state
        @(negedge clk);
        check("R1 irq", {31'b0, irq}, 32'd0);
        check("R1 take", {31'b0, take}, 32'd0);
        check("R1 done", {31'b0, done}, 32'd0);
        reg_read(2'd0, 32'd0, "R1 ctrl");
        reg_read(2'd1, 32'd0, "R1 mask");
        set_cand(1, 40, 0, 8'h10);
        ack_read("R1 ack spurious", v);
        // R2: disabled then enabled
        bus_write(2'd1, 32'hF0, "R3 mask");
        chk_irq("R2 disabled");
        ack_read("R2 disabled ack", v);
        bus_write(2'd0, 32'h1, "R2 enable");
        chk_irq("R2 enabled");
        reg_read(2'd0, 32'd1, "R10 ctrl read");
        reg_read(2'd1, 32'hF0, "R10 mask read");
        reg_read(2'd3, 32'd0, "R10 eoi reads zero");
        // R3: threshold boundary
        set_cand(1, 50, 0, 8'hF0);
        chk_irq("R3 equal blocked");
        ack_read("R3 equal ack", v);
        set_cand(1, 50, 0, 8'hEF);
        chk_irq("R3 below passes");
        // R9: reserved numbers
        set_cand(1, 1020, 0, 8'h00);
        chk_irq("R9 1020");
        ack_read("R9 ack", v);
        set_cand(1, 1023, 0, 8'h00);
        chk_irq("R9 1023");
        // R4/R6: software interrupt with source
        set_cand(1, 5, 6, 8'h40);
        ack_read("R4 swi source", v);
        check("R4 source bits", {29'b0, v[12:10]}, 32'd6);
        chk_irq("R6 drops same prio");
        // R7: preemption signalling while active
        set_cand(1, 60, 2, 8'h40);
        chk_irq("R7 equal prio");
        set_cand(1, 60, 2, 8'h50);
        chk_irq("R7 less urgent");
        set_cand(1, 61, 2, 8'h3F);
        chk_irq("R7 more urgent");
        check("R7 irq high", {31'b0, irq}, 32'd1);
        ack_read("R7 deferred ack", v);
        // R8: mismatched source bits ignored
        bus_write(2'd3, {19'b0, 3'd1, 10'd5}, "R8 wrong src");
        ack_read("R8 still active", v);
        bus_write(2'd3, {19'b0, 3'd6, 10'd5}, "R8 match");
        bus_write(2'd3, {19'b0, 3'd6, 10'd5}, "R8 idle eoi ignored");
        // R4: non-swi source zeroed
        set_cand(1, 100, 7, 8'h20);
        ack_read("R4 spi src zero", v);
        check("R4 spi src", {29'b0, v[12:10]}, 32'd0);
        bus_write(2'd3, {19'b0, v}, "R8 complete spi");
        // random rounds
        for (int i = 0; i < 400; i++) begin
            int r;
            int idp;
            r = int'($urandom_range(0, 99));
            idp = int'($urandom_range(0, 9));
            set_cand($urandom_range(0, 9) != 0,
                     (idp < 3) ? int'($urandom_range(0, 15)) :
                     (idp == 3) ? int'($urandom_range(1018, 1023)) :
                     int'($urandom_range(16, 200)),
                     int'($urandom_range(0, 7)),
                     int'($urandom_range(0, 15)) * 16);
            chk_irq("R7 random irq");
            if (r < 40) ack_read("R6 random ack", v);
            else if (r < 60 && m_act) bus_write(2'd3, {19'b0, m_val}, "R8 random eoi");
            else if (r < 70 && m_act) bus_write(2'd3, {19'b0, m_val ^ 13'h401}, "R8 random bad eoi");
            else if (r < 76) bus_write(2'd1, {24'b0, 8'($urandom_range(0, 15) * 16)}, "R3 random mask");
            else if (r < 79) bus_write(2'd0, {31'b0, 1'($urandom_range(0, 3) != 0)}, "R2 random en");
        end
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule